// File: doc/BRIEF.md
# Binary-Weight Adder-Tree Neuron Core

This block is one processing core of an accelerator for neural networks whose weights are single bits. On each accepted beat it takes five signed activations and five weight bits. A weight bit selects whether the activation is added or subtracted, so no multiplier is needed. The five signed terms pass through a six-input, three-level adder tree. The sixth input is the bias on the first beat of a neuron and the saturated partial sum of the previous beat on later beats.

A neuron may span any number of beats. On the beat flagged as last, the saturated sum goes to an activation stage. That stage applies the function selected for the current layer: pass-through, sign, ReLU or max-pooling over groups of consecutive neurons. A per-beat flag can also switch the activations to one-bit mode, for layers fed by a sign layer. The weight store, the activation buffers and the layer sequencer are outside the block.

Top module: `bwt_neuron_core`

## Requirements
- R1: For each lane, a weight bit of 1 adds the lane's activation to the sum and a weight bit of 0 subtracts it.
- R2: All five lanes are summed in one beat. The first beat of a neuron (first_i=1) adds bias_i. Each later beat adds the saturated partial sum left by the previous accepted beat, and bias_i is ignored on those beats.
- R3: After every beat the partial sum is clamped to the 16-bit signed range [-32768, 32767] and does not wrap. Later beats continue from the clamped value.
- R4: res_valid_o is high for exactly the cycle after a beat with in_valid_i=1 and last_i=1, except as stated in R8. Cycles with in_valid_i=0 leave the partial sum unchanged, whatever the other inputs carry.
- R5: mode_i=0 (linear) outputs the saturated sum as a 16-bit two's-complement value.
- R6: mode_i=1 (sign) outputs 1 in bit 0 when the sum is zero or positive and 0 when it is negative. Bits 15..1 are zero.
- R7: mode_i=2 (ReLU) outputs the sum when it is zero or positive and 0 when it is negative.
- R8: mode_i=3 (pool) raises res_valid_o only after every fourth completed neuron. It then outputs the signed maximum of those four saturated sums.
- R9: With bin_i=1, bit 0 of each activation is read as +1 when it is 1 and -1 when it is 0. Bits 15..1 are ignored.
- R10: Reset drives res_valid_o and res_o to 0 and restarts the pool group count, so the first valid result after reset in pool mode follows the fourth neuron.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Beat accepted this cycle |
| first_i | input | 1 | Beat is the first of a neuron (bias selected) |
| last_i | input | 1 | Beat is the last of a neuron |
| mode_i | input | 2 | Activation: 0 linear, 1 sign, 2 ReLU, 3 pool |
| bin_i | input | 1 | Treat activations as one-bit values |
| act_i | input | 80 | Five 16-bit activations, lane n at bits 16n+15..16n |
| wgt_i | input | 5 | Weight bit per lane, lane n at bit n |
| bias_i | input | 16 | Signed bias, used on the first beat |
| res_o | output | 16 | Activated result |
| res_valid_o | output | 1 | res_o is valid |

## Verification
The hardest condition to reach from the ports is a partial sum that saturates in the middle of a neuron and then has to continue from the clamped value. The stimulus forces this by driving extreme activations with all-add or all-subtract weights on one beat, then an opposite-signed beat, then a small beat, so both clamps are crossed within a single neuron. The pool group boundary is the second hard case. It is reached by counting neurons in the bench and by asserting reset partway through a group. Idle cycles filled with random data are placed between beats to show that they change nothing.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
   typedef enum logic [1:0] {
      ACT_LINEAR = 2'd0,
      ACT_SIGN   = 2'd1,
      ACT_RELU   = 2'd2,
      ACT_POOL   = 2'd3
   } act_mode_e;
endpackage

// File: rtl/bwt_term_gen.sv
// Per-lane signed term: optional one-bit decode, then pass or negate.
module bwt_term_gen #(
   parameter int LANES = 5,
   parameter int DW    = 16
) (
   input  logic [LANES*DW-1:0]     act_i,
   input  logic [LANES-1:0]        wgt_i,
   input  logic                    bin_i,
   output logic [LANES*(DW+1)-1:0] term_o
);
   localparam int TW = DW + 1;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic signed [DW-1:0] a;
      logic signed [TW-1:0] mag;
      logic signed [TW-1:0] term;

      assign a = act_i[g*DW +: DW];

      always_comb begin
         if (bin_i) mag = a[0] ? {{(TW-1){1'b0}}, 1'b1} : {TW{1'b1}};
         else       mag = {a[DW-1], a};
         term = wgt_i[g] ? mag : -mag;
      end

      assign term_o[g*TW +: TW] = term;
   end
endmodule

// File: rtl/bwt_adder_tree.sv
// Six inputs, three levels: 3 adders, then 1 adder plus a pass, then 1 adder.
module bwt_adder_tree #(
   parameter int TW = 17
) (
   input  logic [6*TW-1:0]        in_i,
   output logic signed [TW+2:0]   sum_o
);
   localparam int NIN = 6;
   localparam int SW  = TW + 3;

   logic signed [TW-1:0] op [NIN];
   logic signed [TW:0]   l1 [NIN/2];
   logic signed [TW+1:0] l2a, l2b;

   for (genvar g = 0; g < NIN; g++) begin : g_op
      assign op[g] = in_i[g*TW +: TW];
   end

   for (genvar g = 0; g < NIN/2; g++) begin : g_l1
      assign l1[g] = (TW+1)'(op[2*g]) + (TW+1)'(op[2*g+1]);
   end

   assign l2a   = (TW+2)'(l1[0]) + (TW+2)'(l1[1]);
   assign l2b   = (TW+2)'(l1[2]);
   assign sum_o = SW'(l2a) + SW'(l2b);
endmodule

// File: rtl/bwt_act_unit.sv
// Output register with selectable activation and grouped max.
module bwt_act_unit
   import bwt_pkg::*;
#(
   parameter int DW   = 16,
   parameter int POOL = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 fire_i,
   input  act_mode_e            mode_i,
   input  logic signed [DW-1:0] val_i,
   output logic [DW-1:0]        res_o,
   output logic                 res_valid_o
);
   localparam int CW = (POOL > 1) ? $clog2(POOL) : 1;

   if (POOL < 2) begin : g_bad_pool
      $error("bwt_act_unit: POOL must be at least 2");
   end

   logic signed [DW-1:0] max_q, pool_cand;
   logic [CW-1:0]        cnt_q;

   assign pool_cand = (cnt_q == '0 || val_i > max_q) ? val_i : max_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_o       <= '0;
         res_valid_o <= 1'b0;
         cnt_q       <= '0;
         max_q       <= '0;
      end else begin
         res_valid_o <= 1'b0;
         if (fire_i) begin
            unique case (mode_i)
               ACT_LINEAR: begin
                  res_o       <= val_i;
                  res_valid_o <= 1'b1;
               end
               ACT_SIGN: begin
                  res_o       <= {{(DW-1){1'b0}}, ~val_i[DW-1]};
                  res_valid_o <= 1'b1;
               end
               ACT_RELU: begin
                  res_o       <= val_i[DW-1] ? '0 : val_i;
                  res_valid_o <= 1'b1;
               end
               ACT_POOL: begin
                  max_q <= pool_cand;
                  if (cnt_q == CW'(POOL-1)) begin
                     res_o       <= pool_cand;
                     res_valid_o <= 1'b1;
                     cnt_q       <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            endcase
         end
      end
   end

   assert_sign_bits_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o && $past(mode_i) == ACT_SIGN) |-> res_o[DW-1:1] == '0);

   assert_relu_nonneg_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_valid_o && $past(mode_i) == ACT_RELU) |-> !res_o[DW-1]);
endmodule

// File: rtl/bwt_neuron_core.sv
module bwt_neuron_core
   import bwt_pkg::*;
#(
   parameter int LANES = 5,
   parameter int DW    = 16,
   parameter int POOL  = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                in_valid_i,
   input  logic                first_i,
   input  logic                last_i,
   input  logic [1:0]          mode_i,
   input  logic                bin_i,
   input  logic [LANES*DW-1:0] act_i,
   input  logic [LANES-1:0]    wgt_i,
   input  logic [DW-1:0]       bias_i,
   output logic [DW-1:0]       res_o,
   output logic                res_valid_o
);
   localparam int TW = DW + 1;
   localparam int SW = TW + 3;
   localparam logic signed [SW-1:0] SAT_HI = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [SW-1:0] SAT_LO = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   if (LANES != 5) begin : g_bad_lanes
      $error("bwt_neuron_core: the six-input tree needs LANES == 5");
   end
   if (DW < 4) begin : g_bad_dw
      $error("bwt_neuron_core: DW must be at least 4");
   end

   logic [LANES*TW-1:0]   terms;
   logic signed [DW-1:0]  acc_q, seed, sat_val;
   logic [TW-1:0]         seed_ext;
   logic signed [SW-1:0]  tree_sum;

   bwt_term_gen #(.LANES(LANES), .DW(DW)) u_terms (
      .act_i (act_i),
      .wgt_i (wgt_i),
      .bin_i (bin_i),
      .term_o(terms)
   );

   assign seed     = first_i ? bias_i : acc_q;
   assign seed_ext = {seed[DW-1], seed};

   bwt_adder_tree #(.TW(TW)) u_tree (
      .in_i ({seed_ext, terms}),
      .sum_o(tree_sum)
   );

   always_comb begin
      if (tree_sum > SAT_HI)      sat_val = {1'b0, {(DW-1){1'b1}}};
      else if (tree_sum < SAT_LO) sat_val = {1'b1, {(DW-1){1'b0}}};
      else                        sat_val = tree_sum[DW-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         acc_q <= '0;
      else if (in_valid_i) acc_q <= sat_val;
   end

   bwt_act_unit #(.DW(DW), .POOL(POOL)) u_act (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fire_i     (in_valid_i & last_i),
      .mode_i     (act_mode_e'(mode_i)),
      .val_i      (sat_val),
      .res_o      (res_o),
      .res_valid_o(res_valid_o)
   );

   assert_valid_after_last_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_valid_o |-> $past(in_valid_i && last_i));

   assert_idle_holds_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> $stable(acc_q));
endmodule

// File: tb/bwt_neuron_core_bench.sv
module bwt_neuron_core_bench;
   localparam int LANES = 5;
   localparam int DW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, first_i = 1'b0, last_i = 1'b0, bin_i = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic [LANES*DW-1:0] act_i = '0;
   logic [LANES-1:0] wgt_i = '0;
   logic [DW-1:0] bias_i = '0;
   logic [DW-1:0] res_o;
   logic res_valid_o;

   int n_checks = 0, n_err = 0;
   int act_s [8][LANES];
   logic [LANES-1:0] wgt_s [8];
   int bias_s;
   int pcnt = 0, pmax = 0;

   always #4 clk = ~clk;

   bwt_neuron_core #(.LANES(LANES), .DW(DW), .POOL(4)) u_bwt_neuron_core (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .first_i(first_i),
      .last_i(last_i), .mode_i(mode_i), .bin_i(bin_i), .act_i(act_i),
      .wgt_i(wgt_i), .bias_i(bias_i), .res_o(res_o), .res_valid_o(res_valid_o)
   );

   function automatic int sat16(input int v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input int got, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic fill_random(input int nb, input int span);
      for (int b = 0; b < nb; b++) begin
         wgt_s[b] = LANES'($urandom());
         for (int l = 0; l < LANES; l++) act_s[b][l] = int'($urandom_range(2*span)) - span;
      end
      bias_s = int'($urandom_range(2*span)) - span;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_neuron(input int nb, input logic [1:0] md, input bit bin,
                             input bit gaps, output int acc);
      int s, t, m;
      acc = 0;
      for (int b = 0; b < nb; b++) begin
         if (gaps && b > 0) begin
            int ng = int'($urandom_range(1, 3));
            for (int k = 0; k < ng; k++) begin
               @(negedge clk);
               in_valid = 1'b0;
               act_i    = (LANES*DW)'({$urandom(), $urandom(), $urandom()});
               wgt_i    = LANES'($urandom());
               bias_i   = DW'($urandom());
               first_i  = 1'($urandom());
               last_i   = 1'($urandom());
            end
         end
         @(negedge clk);
         in_valid = 1'b1; first_i = (b == 0); last_i = (b == nb - 1);
         mode_i = md; bin_i = bin; bias_i = DW'(bias_s); wgt_i = wgt_s[b];
         for (int l = 0; l < LANES; l++) act_i[l*DW +: DW] = DW'(act_s[b][l]);
         s = (b == 0) ? bias_s : acc;
         for (int l = 0; l < LANES; l++) begin
            m = bin ? (((act_s[b][l] & 1) != 0) ? 1 : -1) : act_s[b][l];
            t = wgt_s[b][l] ? m : -m;
            s += t;
         end
         acc = sat16(s);
      end
      @(negedge clk);
      in_valid = 1'b0; first_i = 1'b0; last_i = 1'b0;
   endtask

   task automatic expect_out(input int acc, input logic [1:0] md, input string req);
      int exp;
      case (md)
         2'd1:    exp = (acc >= 0) ? 1 : 0;
         2'd2:    exp = (acc < 0) ? 0 : acc;
         default: exp = acc;
      endcase
      check(res_valid_o == 1'b1, req, int'(res_valid_o), 1);
      if (md == 2'd1) check(res_o == DW'(exp), req, int'(res_o), exp);
      else            check(int'($signed(res_o)) == exp, req, int'($signed(res_o)), exp);
   endtask

   task automatic pool_step(input int acc);
      pmax = (pcnt == 0 || acc > pmax) ? acc : pmax;
      pcnt++;
      if (pcnt == 4) begin
         check(res_valid_o == 1'b1, "R8 valid on fourth", int'(res_valid_o), 1);
         check(int'($signed(res_o)) == pmax, "R8 max", int'($signed(res_o)), pmax);
         pcnt = 0;
      end else begin
         check(res_valid_o == 1'b0, "R8 no valid mid-group", int'(res_valid_o), 0);
      end
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      int acc;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(res_valid_o == 1'b0, "R10 reset valid", int'(res_valid_o), 0);
      check(res_o == '0, "R10 reset result", int'(res_o), 0);
      rst_n = 1'b1;

      // R1 every weight pattern, distinct power-of-two activations
      for (int p = 0; p < 32; p++) begin
         for (int l = 0; l < LANES; l++) act_s[0][l] = 100 << l;
         wgt_s[0] = LANES'(p); bias_s = 0;
         run_neuron(1, 2'd0, 1'b0, 1'b0, acc);
         expect_out(acc, 2'd0, "R1 weight pattern");
      end

      // R2 / R4 / R5 multi-beat linear, with idle garbage on some
      for (int n = 0; n < 40; n++) begin
         int nb = int'($urandom_range(1, 6));
         fill_random(nb, 2000);
         run_neuron(nb, 2'd0, 1'b0, (n % 2) == 1, acc);
         expect_out(acc, 2'd0, (n % 2) ? "R4 idle gaps" : "R2 multi-beat R5");
      end

      // R3 saturation corners
      for (int l = 0; l < LANES; l++) act_s[0][l] = 32767;
      for (int l = 0; l < LANES; l++) act_s[1][l] = 32767;
      wgt_s[0] = '1; wgt_s[1] = '1; bias_s = 32767;
      run_neuron(2, 2'd0, 1'b0, 1'b0, acc);
      expect_out(acc, 2'd0, "R3 clamp high");
      for (int l = 0; l < LANES; l++) act_s[0][l] = -32768;
      wgt_s[0] = '1; bias_s = -32768;
      run_neuron(1, 2'd0, 1'b0, 1'b0, acc);
      expect_out(acc, 2'd0, "R3 clamp low");
      wgt_s[0] = '0; bias_s = 0;
      run_neuron(1, 2'd0, 1'b0, 1'b0, acc);
      expect_out(acc, 2'd0, "R3 negated minimum");
      for (int l = 0; l < LANES; l++) begin
         act_s[0][l] = 32767; act_s[1][l] = 30000; act_s[2][l] = 1000;
      end
      wgt_s[0] = '1; wgt_s[1] = '0; wgt_s[2] = '1; bias_s = 0;
      run_neuron(3, 2'd0, 1'b0, 1'b1, acc);
      expect_out(acc, 2'd0, "R3 continue from clamp");
      check(acc == -27768, "R3 reference sanity", acc, -27768);

      // R6 sign, including an exact zero
      for (int l = 0; l < LANES; l++) act_s[0][l] = 0;
      wgt_s[0] = 5'b10101; bias_s = 0;
      run_neuron(1, 2'd1, 1'b0, 1'b0, acc);
      expect_out(acc, 2'd1, "R6 zero is positive");
      for (int n = 0; n < 30; n++) begin
         int nb = int'($urandom_range(1, 4));
         fill_random(nb, 3000);
         run_neuron(nb, 2'd1, 1'b0, 1'b0, acc);
         expect_out(acc, 2'd1, "R6 sign");
      end

      // R7 ReLU
      for (int n = 0; n < 30; n++) begin
         int nb = int'($urandom_range(1, 4));
         fill_random(nb, 3000);
         run_neuron(nb, 2'd2, 1'b0, 1'b0, acc);
         expect_out(acc, 2'd2, "R7 relu");
      end

      // R9 one-bit activations, upper bits random
      for (int n = 0; n < 30; n++) begin
         int nb = int'($urandom_range(1, 6));
         logic [1:0] md = (n % 3 == 0) ? 2'd1 : 2'd0;
         fill_random(nb, 30000);
         bias_s = int'($urandom_range(40)) - 20;
         run_neuron(nb, md, 1'b1, 1'b0, acc);
         expect_out(acc, md, "R9 binarized input");
      end

      // R8 pool groups
      pcnt = 0;
      for (int n = 0; n < 12; n++) begin
         int nb = int'($urandom_range(1, 3));
         fill_random(nb, 4000);
         run_neuron(nb, 2'd3, 1'b0, 1'b0, acc);
         pool_step(acc);
      end

      // R10 reset in mid-group restarts the count
      for (int n = 0; n < 2; n++) begin
         fill_random(1, 4000);
         run_neuron(1, 2'd3, 1'b0, 1'b0, acc);
         pool_step(acc);
      end
      do_reset();
      pcnt = 0;
      for (int n = 0; n < 4; n++) begin
         fill_random(2, 4000);
         run_neuron(2, 2'd3, 1'b0, 1'b1, acc);
         pool_step(acc);
      end
      check(pcnt == 0, "R10 group aligned after reset", pcnt, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule